// File: doc/BRIEF.md
# Ring Bus FIFO Peripheral Endpoint

This block is one peripheral slot on a serpentine 8-bit bus. The bus controller drives a strobe, a write flag, an address tag and an 8-bit register address to every slot. The data byte travels around the ring from slot to slot. A slot that is not addressed forwards the incoming byte unchanged. The addressed slot replaces the byte with its own read data.

The slot holds a byte FIFO that is reached through one register address. A write to that address pushes a byte and a read from it pops a byte. The acknowledge line tells the controller whether the byte was taken or delivered, so a burst stops when the FIFO is full or empty. When the address tag is low, the access is a poll: the slot answers with the number of bytes it has waiting for the host.

For testing without pin logic, the slot also has a loopback source. When it is enabled, it fills the FIFO with a counting byte sequence that starts at a programmable seed. Every access finishes in the cycle in which it is presented. Reset is synchronous and active high.

Top module: `ringbus_fifo_slot`

## Requirements
- R1: While the strobe is low, the outgoing data equals the incoming data in every cycle, and acknowledge is low.
- R2: With the strobe and tag high, a write latches the incoming byte into the addressed register at that clock edge. A read drives the register's value out in the same cycle and ignores the incoming byte. A selected write drives 0x00 out. Address 1 is the control register, with loopback enable in bit 0 and bits 7..1 reading as zero. Address 2 is the 8-bit seed register.
- R3: With the strobe high and the tag low, the outgoing byte is the FIFO occupancy clamped to 255. It is 0x00 when the FIFO is empty. Acknowledge is high, and the occupancy does not change.
- R4: A write to address 0 stores the byte and raises acknowledge only when the FIFO is not full. When the FIFO is full, acknowledge stays low and the byte is dropped.
- R5: A read from address 0 raises acknowledge and returns the oldest stored byte when the FIFO is not empty, and removes that byte. When the FIFO is empty, acknowledge stays low and the outgoing byte is 0x00.
- R6: Accesses to addresses 1 to 255 always raise acknowledge. Address 3 reads the clamped occupancy and ignores writes. Addresses 4 to 255 read 0x00 and ignore writes.
- R7: Stall is never raised; every access completes in the cycle in which it is presented.
- R8: While loopback is enabled, the slot pushes the seed value and then increments the seed at every clock edge where the FIFO has room (or a byte is popped in that cycle) and no bus write to address 0 is presented.
- R9: A loopback push and a bus pop at the same edge leave the occupancy unchanged. The popped byte is the oldest, and the pushed byte becomes the newest.
- R10: After reset, the FIFO is empty and both the control register and the seed register are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | 1 = write to slot, 0 = read from slot |
| bus_stb | input | 1 | Slot is addressed in this cycle |
| bus_tag | input | 1 | 1 = register access, 0 = poll |
| bus_adr | input | 8 | Register address |
| bus_din | input | 8 | Ring data arriving at the slot |
| bus_stall | output | 1 | Extra cycles needed (always 0) |
| bus_ack | output | 1 | Access accepted / byte moved |
| bus_dout | output | 8 | Ring data leaving the slot |

## Verification
The pass-through check sweeps all 256 data values with the strobe low while address, tag and write flag vary. This separates real forwarding from forwarding that depends on any decode input. The FIFO is filled to full and drained to empty over several rounds whose lengths force pointer wrap. Each step is paired with a poll, which shows ordering, the full/empty acknowledge edges and the exact occupancy. Every unmapped address is both written and read, and writes to the occupancy address are tried, to confirm that none of them disturb stored state. A loopback run with a seed just below 0xFF checks seed wraparound, the stop at full, and the pop-with-push case in which the occupancy must stay at its maximum.

// File: rtl/ringbus_fifo_pkg.sv
package ringbus_fifo_pkg;

    localparam int unsigned DATA_W = 8;

    localparam logic [7:0] ADR_FIFO = 8'h00;
    localparam logic [7:0] ADR_CTRL = 8'h01;
    localparam logic [7:0] ADR_SEED = 8'h02;
    localparam logic [7:0] ADR_OCC  = 8'h03;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_POLL,
        ACC_FIFO,
        ACC_CTRL,
        ACC_SEED,
        ACC_OCC,
        ACC_NONE
    } acc_kind_e;

    typedef struct packed {
        logic              lb_en;
        logic [DATA_W-1:0] seed;
    } cfg_state_t;

    typedef struct packed {
        logic              full;
        logic              empty;
        logic [DATA_W-1:0] head;
    } fifo_view_t;

    function automatic logic [7:0] clamp_count(input logic [31:0] n);
        return (n > 32'd255) ? 8'hFF : n[7:0];
    endfunction

endpackage

// File: rtl/ringbus_fifo_decode.sv
module ringbus_fifo_decode
    import ringbus_fifo_pkg::*;
(
    input  logic       stb,
    input  logic       tag,
    input  logic [7:0] adr,
    output acc_kind_e  kind
);
    always_comb begin
        if (!stb) begin
            kind = ACC_IDLE;
        end else if (!tag) begin
            kind = ACC_POLL;
        end else begin
            unique case (adr)
                ADR_FIFO: kind = ACC_FIFO;
                ADR_CTRL: kind = ACC_CTRL;
                ADR_SEED: kind = ACC_SEED;
                ADR_OCC:  kind = ACC_OCC;
                default:  kind = ACC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ringbus_fifo_store.sv
module ringbus_fifo_store
    import ringbus_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output fifo_view_t        view,
    output logic [CW-1:0]     count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= step(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= step(rd_ptr);
            end
            if (push && !pop) begin
                count <= count + CW'(1);
            end else if (pop && !push) begin
                count <= count - CW'(1);
            end
        end
    end

    always_comb begin
        view.full  = (count == CW'(DEPTH));
        view.empty = (count == '0);
        view.head  = mem[rd_ptr];
    end
endmodule

// File: rtl/ringbus_fifo_cfg.sv
module ringbus_fifo_cfg
    import ringbus_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_seed,
    input  logic [DATA_W-1:0] din,
    input  logic              lb_fire,
    output cfg_state_t        cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.lb_en <= 1'b0;
            cfg.seed  <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.lb_en <= din[0];
            end
            if (wr_seed) begin
                cfg.seed <= din;
            end else if (lb_fire) begin
                cfg.seed <= cfg.seed + DATA_W'(1);
            end
        end
    end
endmodule

// File: rtl/ringbus_fifo_slot.sv
module ringbus_fifo_slot
    import ringbus_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_we,
    input  logic       bus_stb,
    input  logic       bus_tag,
    input  logic [7:0] bus_adr,
    input  logic [7:0] bus_din,
    output logic       bus_stall,
    output logic       bus_ack,
    output logic [7:0] bus_dout
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    acc_kind_e         kind;
    fifo_view_t        fview;
    cfg_state_t        cfg;
    logic [CW-1:0]     occ;
    logic [7:0]        occ_byte;
    logic              fifo_wr_req;
    logic              bus_push;
    logic              bus_pop;
    logic              lb_push;
    logic              fifo_push;
    logic [DATA_W-1:0] fifo_wdata;

    ringbus_fifo_decode u_dec (
        .stb  (bus_stb),
        .tag  (bus_tag),
        .adr  (bus_adr),
        .kind (kind)
    );

    assign fifo_wr_req = (kind == ACC_FIFO) && bus_we;
    assign bus_push    = fifo_wr_req && !fview.full;
    assign bus_pop     = (kind == ACC_FIFO) && !bus_we && !fview.empty;
    assign lb_push     = cfg.lb_en && !fifo_wr_req && (!fview.full || bus_pop);
    assign fifo_push   = bus_push || lb_push;
    assign fifo_wdata  = bus_push ? bus_din : cfg.seed;

    ringbus_fifo_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .pop   (bus_pop),
        .wdata (fifo_wdata),
        .view  (fview),
        .count (occ)
    );

    ringbus_fifo_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl ((kind == ACC_CTRL) && bus_we),
        .wr_seed ((kind == ACC_SEED) && bus_we),
        .din     (bus_din),
        .lb_fire (lb_push),
        .cfg     (cfg)
    );

    assign occ_byte  = clamp_count(32'(occ));
    assign bus_stall = 1'b0;

    always_comb begin
        bus_ack  = 1'b1;
        bus_dout = 8'h00;
        unique case (kind)
            ACC_IDLE: begin
                bus_ack  = 1'b0;
                bus_dout = bus_din;
            end
            ACC_POLL: bus_dout = occ_byte;
            ACC_FIFO: begin
                if (bus_we) begin
                    bus_ack = !fview.full;
                end else begin
                    bus_ack  = !fview.empty;
                    bus_dout = fview.empty ? 8'h00 : fview.head;
                end
            end
            ACC_CTRL: bus_dout = bus_we ? 8'h00 : {7'b0, cfg.lb_en};
            ACC_SEED: bus_dout = bus_we ? 8'h00 : cfg.seed;
            ACC_OCC:  bus_dout = bus_we ? 8'h00 : occ_byte;
            default:  bus_dout = 8'h00;
        endcase
    end
endmodule

// File: rtl/ringbus_fifo_slot_chk.sv
module ringbus_fifo_slot_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_we,
    input logic          bus_stb,
    input logic          bus_tag,
    input logic [7:0]    bus_adr,
    input logic [7:0]    bus_din,
    input logic [7:0]    bus_dout,
    input logic          bus_ack,
    input logic [CW-1:0] count,
    input logic          push,
    input logic          pop
);
    p_passthru_r1: assert property (@(posedge clk) disable iff (rst)
        !bus_stb |-> (bus_dout == bus_din) && !bus_ack);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_full_nack_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_tag && bus_we && bus_adr == 8'h00 && count == CW'(DEPTH))
        |-> !bus_ack);

    p_empty_nack_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && bus_tag && !bus_we && bus_adr == 8'h00 && count == '0)
        |-> !bus_ack && bus_dout == 8'h00);

    p_poll_empty_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_tag && count == '0) |-> bus_dout == 8'h00 && bus_ack);

    p_hold_occ_r9: assert property (@(posedge clk) disable iff (rst)
        (push && pop) |=> $stable(count));
endmodule

bind ringbus_fifo_slot ringbus_fifo_slot_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .bus_stb  (bus_stb),
    .bus_tag  (bus_tag),
    .bus_adr  (bus_adr),
    .bus_din  (bus_din),
    .bus_dout (bus_dout),
    .bus_ack  (bus_ack),
    .count    (occ),
    .push     (fifo_push),
    .pop      (bus_pop)
);

// File: tb/ringbus_fifo_slot_test.sv
module ringbus_fifo_slot_test;
    localparam int unsigned DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic       bus_stb = 1'b0;
    logic       bus_tag = 1'b1;
    logic [7:0] bus_adr = 8'h00;
    logic [7:0] bus_din = 8'h00;
    logic       bus_stall;
    logic       bus_ack;
    logic [7:0] bus_dout;

    int total = 0;
    int fails = 0;
    int stall_seen = 0;

    always #10 clk = ~clk;

    always @(negedge clk) if (!rst && bus_stall) stall_seen++;

    ringbus_fifo_slot #(.DEPTH(DEPTH)) uut (
        .clk, .rst, .bus_we, .bus_stb, .bus_tag, .bus_adr, .bus_din,
        .bus_stall, .bus_ack, .bus_dout
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic tag, input logic [7:0] adr,
                          input logic [7:0] din, output logic [7:0] dout,
                          output logic ack);
        @(negedge clk);
        bus_stb = 1'b1; bus_we = we; bus_tag = tag; bus_adr = adr; bus_din = din;
        #2;
        dout = bus_dout;
        ack  = bus_ack;
        @(posedge clk);
        #1;
        bus_stb = 1'b0; bus_we = 1'b0; bus_tag = 1'b1; bus_din = 8'h00;
    endtask

    task automatic expect_acc(input string req, input logic we, input logic tag,
                              input logic [7:0] adr, input logic [7:0] din,
                              input int exp_dout, input int exp_ack);
        logic [7:0] d;
        logic a;
        access(we, tag, adr, din, d, a);
        check(req, int'(d), exp_dout);
        check(req, int'(a), exp_ack);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R10 reset state
        expect_acc("R10 poll", 0, 0, 8'h00, 8'h00, 0, 1);
        expect_acc("R10 ctrl", 0, 1, 8'h01, 8'hFF, 0, 1);
        expect_acc("R10 seed", 0, 1, 8'h02, 8'hFF, 0, 1);
        expect_acc("R10 empty read", 0, 1, 8'h00, 8'h5A, 0, 0);

        // R1 pass-through sweep
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            bus_stb = 1'b0; bus_din = 8'(i); bus_adr = 8'(i * 7);
            bus_we = i[0]; bus_tag = i[1];
            #2;
            check("R1 passthrough", int'(bus_dout), i);
            check("R1 ack low", int'(bus_ack), 0);
        end
        @(negedge clk);
        bus_we = 1'b0; bus_tag = 1'b1; bus_adr = 8'h00;

        // R4 / R5 / R3 fill and drain
        for (int i = 0; i < DEPTH; i++) begin
            expect_acc("R4 push", 1, 1, 8'h00, 8'(8'h30 + i * 8'h11), 0, 1);
            expect_acc("R3 poll count", 0, 0, 8'h00, 8'hEE, i + 1, 1);
        end
        expect_acc("R4 full push nack", 1, 1, 8'h00, 8'hC3, 0, 0);
        expect_acc("R3 poll full", 0, 0, 8'h00, 8'h00, DEPTH, 1);
        expect_acc("R6 occupancy reg", 0, 1, 8'h03, 8'h00, DEPTH, 1);
        for (int i = 0; i < DEPTH; i++) begin
            expect_acc("R5 pop order", 0, 1, 8'h00, 8'hAA, 8'h30 + i * 8'h11, 1);
            expect_acc("R3 poll drain", 0, 0, 8'h00, 8'h00, DEPTH - 1 - i, 1);
        end
        expect_acc("R5 empty pop nack", 0, 1, 8'h00, 8'h77, 0, 0);

        // R4 / R5 pointer wrap rounds
        for (int r = 0; r < 5; r++) begin
            for (int k = 0; k < 3; k++)
                expect_acc("R4 wrap push", 1, 1, 8'h00, 8'((r * 3 + k) * 7 + 1), 0, 1);
            for (int k = 0; k < 3; k++)
                expect_acc("R5 wrap pop", 0, 1, 8'h00, 8'h00, ((r * 3 + k) * 7 + 1) & 8'hFF, 1);
        end

        // R2 seed / control registers
        for (int i = 0; i < 256; i += 37) begin
            expect_acc("R2 seed write", 1, 1, 8'h02, 8'(i), 0, 1);
            expect_acc("R2 seed read", 0, 1, 8'h02, 8'(~i), i, 1);
        end
        expect_acc("R2 seed write", 1, 1, 8'h02, 8'h6B, 0, 1);
        expect_acc("R2 ctrl write", 1, 1, 8'h01, 8'hFE, 0, 1);
        expect_acc("R2 ctrl read", 0, 1, 8'h01, 8'hFF, 0, 1);

        // R6 writes ignored at occupancy and unmapped addresses
        expect_acc("R6 occ write", 1, 1, 8'h03, 8'h55, 0, 1);
        expect_acc("R6 occ unchanged", 0, 1, 8'h03, 8'h00, 0, 1);
        for (int a = 4; a < 256; a++)
            expect_acc("R6 unmapped write", 1, 1, 8'(a), 8'hFF, 0, 1);
        for (int a = 4; a < 256; a++)
            expect_acc("R6 unmapped read", 0, 1, 8'(a), 8'hA5, 0, 1);
        expect_acc("R6 seed kept", 0, 1, 8'h02, 8'h00, 8'h6B, 1);
        expect_acc("R6 ctrl kept", 0, 1, 8'h01, 8'h00, 0, 1);
        expect_acc("R6 fifo kept empty", 0, 0, 8'h00, 8'h00, 0, 1);

        // R8 loopback with seed wrap
        expect_acc("R8 seed set", 1, 1, 8'h02, 8'hFE, 0, 1);
        expect_acc("R8 enable", 1, 1, 8'h01, 8'h01, 0, 1);
        repeat (6) @(posedge clk);
        expect_acc("R8 poll full", 0, 0, 8'h00, 8'h00, DEPTH, 1);
        expect_acc("R8 seed after fill", 0, 1, 8'h02, 8'h00, 8'h02, 1);
        expect_acc("R8 ctrl read", 0, 1, 8'h01, 8'h00, 1, 1);
        // R9 pop while loopback refills
        expect_acc("R9 pop head", 0, 1, 8'h00, 8'h00, 8'hFE, 1);
        expect_acc("R9 poll unchanged", 0, 0, 8'h00, 8'h00, DEPTH, 1);
        expect_acc("R9 seed advanced", 0, 1, 8'h02, 8'h00, 8'h03, 1);
        expect_acc("R8 disable", 1, 1, 8'h01, 8'h00, 0, 1);
        for (int i = 0; i < DEPTH; i++) begin
            v = 8'(8'hFF + i);
            expect_acc("R9 drain order", 0, 1, 8'h00, 8'h00, v, 1);
        end
        expect_acc("R8 empty after drain", 0, 1, 8'h00, 8'h00, 0, 0);
        expect_acc("R8 poll zero", 0, 0, 8'h00, 8'h00, 0, 1);

        // R7 stall never seen
        check("R7 stall", stall_seen, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule